// File: doc/BRIEF.md
# Endpoint Handshake Response Selector

This block picks the handshake that a full-speed device endpoint returns for every token seen on the bus. It keeps two pieces of per-endpoint state, a stall flag and a NAK flag, and weighs them against the global IN-NAK and OUT-NAK flags and against FIFO readiness. Readiness means data waiting for an IN token, or room for an OUT packet. For each token it registers one response code, which is valid for a single cycle.

Software changes the state through a one-cycle write strobe. The strobe carries three bits: set stall, set NAK and clear NAK. The packet engine can also force the NAK flag on with a request line. The block also turns the two-bit control-endpoint packet-size code into a byte count.

Packet framing, CRC, data toggling and the FIFOs themselves are outside this block.

Top module: `ep_handshake_sel`

## Requirements
- R1: Each token with `tokType` 00 (OUT), 01 (IN) or 10 (SETUP) gives `respValid` high for exactly the one cycle after the token strobe. Code 11 gives no response.
- R2: A SETUP token is always answered with `respCode` 00 (ACK), whatever the stall, NAK, global NAK and FIFO inputs are.
- R3: `stallActive` is set by a write with `wrSetStall`=1. A write with `wrSetStall`=0 leaves it unchanged.
- R4: A SETUP token clears `stallActive` in the cycle after the strobe. If a stall-setting write arrives in that same cycle, the set wins.
- R5: While `stallActive` is 1, IN and OUT tokens get `respCode` 10 (STALL), even when endpoint NAK or either global NAK is also set.
- R6: While `nakStatus` is 1 and stall is off, IN and OUT tokens get `respCode` 01 (NAK), even when the FIFO is ready.
- R7: `globInNak` forces NAK on IN tokens only. `globOutNak` forces NAK on OUT tokens only.
- R8: With no stall and no NAK source active, an IN token gives 11 (DATA) if `txReady` is 1, else 01 (NAK). An OUT token gives 00 (ACK) if `rxRoom` is 1, else 01 (NAK).
- R9: A write with `wrSetNak` sets `nakStatus`, and so does `ctrlNakReq`. A write with `wrClearNak` clears it. When a set and a clear arrive in the same cycle, the set wins.
- R10: `maxPktBytes` decodes `mpsCode` 00/01/10/11 as 64/32/16/8.
- R11: After reset, `stallActive`, `nakStatus` and `respValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | Token strobe |
| tokType | input | 2 | 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| txReady | input | 1 | Transmit FIFO holds a packet |
| rxRoom | input | 1 | Receive FIFO has room |
| globInNak | input | 1 | Global non-periodic IN NAK |
| globOutNak | input | 1 | Global OUT NAK |
| wrEn | input | 1 | Software write strobe |
| wrSetStall | input | 1 | Write bit: set stall |
| wrSetNak | input | 1 | Write bit: set NAK |
| wrClearNak | input | 1 | Write bit: clear NAK |
| ctrlNakReq | input | 1 | Packet engine request to set NAK |
| mpsCode | input | 2 | Control-endpoint packet-size code |
| respValid | output | 1 | Response valid pulse |
| respCode | output | 2 | 00 ACK, 01 NAK, 10 STALL, 11 DATA |
| nakStatus | output | 1 | Endpoint NAK flag |
| stallActive | output | 1 | Endpoint stall flag |
| maxPktBytes | output | 7 | Decoded maximum packet size in bytes |

## Verification
The priority chain is driven with a table of vectors, each of which starts from reset.

- Ready and not-ready FIFO cases for both directions show that plain FIFO status controls the answer.
- Each global NAK is applied against both token directions, which separates direction-specific masking from a blanket NAK.
- Vectors that stack stall on top of every NAK source show stall winning.
- SETUP vectors with everything active show that SETUP is exempt.

Directed cases then cover:
- same-cycle set and clear collisions;
- the stall being cleared by SETUP;
- the reserved token code and the width of the response pulse;
- the four packet-size codes.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_RSVD  = 2'b11
  } tokKind_e;

  typedef enum logic [1:0] {
    RSP_ACK   = 2'b00,
    RSP_NAK   = 2'b01,
    RSP_STALL = 2'b10,
    RSP_DATA  = 2'b11
  } rspKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     setStall;
    logic     clrStall;
    logic     setNak;
    logic     clrNak;
    logic     loadResp;
    rspKind_e respNext;
  } hsStrobes_t;

endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import usb_hs_pkg::*;
(
  input  logic       tokValid,
  input  logic [1:0] tokType,
  input  logic       txReady,
  input  logic       rxRoom,
  input  logic       globInNak,
  input  logic       globOutNak,
  input  logic       wrEn,
  input  logic       wrSetStall,
  input  logic       wrSetNak,
  input  logic       wrClearNak,
  input  logic       ctrlNakReq,
  input  logic       stallQ,
  input  logic       nakQ,
  output hsStrobes_t stb
);

  tokKind_e tok;

  always_comb begin
    tok          = tokKind_e'(tokType);
    stb          = '0;
    stb.setStall = wrEn && wrSetStall;
    stb.clrStall = tokValid && (tok == TOK_SETUP);
    stb.setNak   = (wrEn && wrSetNak) || ctrlNakReq;
    stb.clrNak   = wrEn && wrClearNak;
    stb.loadResp = tokValid && (tok != TOK_RSVD);
    stb.respNext = RSP_NAK;
    unique case (tok)
      TOK_SETUP: stb.respNext = RSP_ACK;
      TOK_IN: begin
        if (stallQ)                 stb.respNext = RSP_STALL;
        else if (nakQ || globInNak) stb.respNext = RSP_NAK;
        else if (txReady)           stb.respNext = RSP_DATA;
        else                        stb.respNext = RSP_NAK;
      end
      TOK_OUT: begin
        if (stallQ)                  stb.respNext = RSP_STALL;
        else if (nakQ || globOutNak) stb.respNext = RSP_NAK;
        else if (rxRoom)             stb.respNext = RSP_ACK;
        else                         stb.respNext = RSP_NAK;
      end
      default: stb.respNext = RSP_NAK;
    endcase
  end

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import usb_hs_pkg::*;
#(
  parameter int MPS_MAX_BYTES = 64,
  localparam int MPS_W = $clog2(MPS_MAX_BYTES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobes_t       stb,
  input  logic [1:0]       mpsCode,
  output logic             stallQ,
  output logic             nakQ,
  output logic             respValid,
  output logic [1:0]       respCode,
  output logic [MPS_W-1:0] maxPktBytes
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallQ    <= 1'b0;
      nakQ      <= 1'b0;
      respValid <= 1'b0;
      respCode  <= RSP_ACK;
    end else begin
      if (stb.setStall)      stallQ <= 1'b1;
      else if (stb.clrStall) stallQ <= 1'b0;
      if (stb.setNak)        nakQ   <= 1'b1;
      else if (stb.clrNak)   nakQ   <= 1'b0;
      respValid <= stb.loadResp;
      if (stb.loadResp) respCode <= stb.respNext;
    end
  end

  always_comb maxPktBytes = MPS_W'(MPS_MAX_BYTES >> mpsCode);

endmodule

// File: rtl/ep_handshake_sel.sv
module ep_handshake_sel
  import usb_hs_pkg::*;
#(
  parameter int MPS_MAX_BYTES = 64,
  localparam int MPS_W = $clog2(MPS_MAX_BYTES + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokValid,
  input  logic [1:0]       tokType,
  input  logic             txReady,
  input  logic             rxRoom,
  input  logic             globInNak,
  input  logic             globOutNak,
  input  logic             wrEn,
  input  logic             wrSetStall,
  input  logic             wrSetNak,
  input  logic             wrClearNak,
  input  logic             ctrlNakReq,
  input  logic [1:0]       mpsCode,
  output logic             respValid,
  output logic [1:0]       respCode,
  output logic             nakStatus,
  output logic             stallActive,
  output logic [MPS_W-1:0] maxPktBytes
);

  hsStrobes_t stb;
  logic       stallQ;
  logic       nakQ;

  hs_ctrl uCtrl (
    .tokValid   (tokValid),
    .tokType    (tokType),
    .txReady    (txReady),
    .rxRoom     (rxRoom),
    .globInNak  (globInNak),
    .globOutNak (globOutNak),
    .wrEn       (wrEn),
    .wrSetStall (wrSetStall),
    .wrSetNak   (wrSetNak),
    .wrClearNak (wrClearNak),
    .ctrlNakReq (ctrlNakReq),
    .stallQ     (stallQ),
    .nakQ       (nakQ),
    .stb        (stb)
  );

  hs_datapath #(.MPS_MAX_BYTES(MPS_MAX_BYTES)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .mpsCode     (mpsCode),
    .stallQ      (stallQ),
    .nakQ        (nakQ),
    .respValid   (respValid),
    .respCode    (respCode),
    .maxPktBytes (maxPktBytes)
  );

  assign nakStatus   = nakQ;
  assign stallActive = stallQ;

endmodule

// File: rtl/ep_handshake_sel_chk.sv
module ep_handshake_sel_chk #(
  parameter int MPS_MAX_BYTES = 64,
  localparam int MPS_W = $clog2(MPS_MAX_BYTES + 1)
)(
  input logic             clk,
  input logic             rstN,
  input logic             tokValid,
  input logic [1:0]       tokType,
  input logic             txReady,
  input logic             rxRoom,
  input logic             globInNak,
  input logic             globOutNak,
  input logic             wrEn,
  input logic             wrSetStall,
  input logic             wrSetNak,
  input logic             wrClearNak,
  input logic             ctrlNakReq,
  input logic [1:0]       mpsCode,
  input logic             respValid,
  input logic [1:0]       respCode,
  input logic             nakStatus,
  input logic             stallActive,
  input logic [MPS_W-1:0] maxPktBytes
);

  a_r1_pulse_after_token: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType != 2'b11) |=> respValid);

  a_r1_quiet_without_token: assert property (@(posedge clk) disable iff (!rstN)
    !(tokValid && tokType != 2'b11) |=> !respValid);

  a_r2_setup_acked: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType == 2'b10) |=> (respCode == 2'b00));

  a_r3_stall_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSetStall) |=> stallActive);

  a_r4_setup_clears_stall: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType == 2'b10 && !(wrEn && wrSetStall)) |=> !stallActive);

  a_r5_stall_overrides: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType[1] == 1'b0 && stallActive) |=> (respCode == 2'b10));

  a_r6_nak_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokType[1] == 1'b0 && !stallActive && nakStatus) |=> (respCode == 2'b01));

  a_r9_ctrl_nak_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctrlNakReq |=> nakStatus);

endmodule

bind ep_handshake_sel ep_handshake_sel_chk #(.MPS_MAX_BYTES(MPS_MAX_BYTES)) uChk (.*);

// File: tb/ep_handshake_sel_test.sv
module ep_handshake_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {tok[1:0], tx, rx, gIn, gOut, stall, nak, exp[1:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b01_1000_00_11, // IN ready -> DATA (R8)
    10'b01_0000_00_01, // IN empty -> NAK (R8)
    10'b00_0100_00_00, // OUT room -> ACK (R8)
    10'b00_0000_00_01, // OUT full -> NAK (R8)
    10'b01_1010_00_01, // IN + global IN NAK (R7)
    10'b01_1001_00_11, // IN + global OUT NAK unaffected (R7)
    10'b00_0101_00_01, // OUT + global OUT NAK (R7)
    10'b00_0110_00_00, // OUT + global IN NAK unaffected (R7)
    10'b01_1000_01_01, // IN + ep NAK (R6)
    10'b00_0100_01_01, // OUT + ep NAK (R6)
    10'b01_1010_11_10, // IN stall over NAKs (R5)
    10'b00_0101_11_10, // OUT stall over NAKs (R5)
    10'b10_0011_11_00, // SETUP with everything (R2)
    10'b10_0000_00_00  // SETUP plain (R2)
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tokValid = 1'b0;
  logic [1:0] tokType = 2'b00;
  logic       txReady = 1'b0, rxRoom = 1'b0, globInNak = 1'b0, globOutNak = 1'b0;
  logic       wrEn = 1'b0, wrSetStall = 1'b0, wrSetNak = 1'b0, wrClearNak = 1'b0;
  logic       ctrlNakReq = 1'b0;
  logic [1:0] mpsCode = 2'b00;
  logic       respValid, nakStatus, stallActive;
  logic [1:0] respCode;
  logic [6:0] maxPktBytes;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_handshake_sel uut (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokType(tokType),
    .txReady(txReady), .rxRoom(rxRoom), .globInNak(globInNak), .globOutNak(globOutNak),
    .wrEn(wrEn), .wrSetStall(wrSetStall), .wrSetNak(wrSetNak), .wrClearNak(wrClearNak),
    .ctrlNakReq(ctrlNakReq), .mpsCode(mpsCode), .respValid(respValid),
    .respCode(respCode), .nakStatus(nakStatus), .stallActive(stallActive),
    .maxPktBytes(maxPktBytes)
  );

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic st, input logic sn, input logic cn);
    @(negedge clk);
    wrEn = 1'b1; wrSetStall = st; wrSetNak = sn; wrClearNak = cn;
    @(negedge clk);
    wrEn = 1'b0; wrSetStall = 1'b0; wrSetNak = 1'b0; wrClearNak = 1'b0;
  endtask

  task automatic doToken(input logic [1:0] kind, output logic v, output logic [1:0] code);
    @(negedge clk);
    tokValid = 1'b1; tokType = kind;
    @(negedge clk);
    tokValid = 1'b0;
    v = respValid; code = respCode;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic       v;
    logic [1:0] c;

    // R11: reset state
    doReset();
    check("R11 stall after reset", stallActive, 0);
    check("R11 nak after reset", nakStatus, 0);
    check("R11 respValid after reset", respValid, 0);

    // table walk, each vector from reset
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      txReady = VEC[i][7]; rxRoom = VEC[i][6];
      globInNak = VEC[i][5]; globOutNak = VEC[i][4];
      if (VEC[i][3]) doWrite(1'b1, 1'b0, 1'b0);
      if (VEC[i][2]) doWrite(1'b0, 1'b1, 1'b0);
      doToken(VEC[i][9:8], v, c);
      check($sformatf("R1 valid vec%0d", i), v, 1);
      check($sformatf("R2/R5..R8 code vec%0d", i), c, VEC[i][1:0]);
      txReady = 1'b0; rxRoom = 1'b0; globInNak = 1'b0; globOutNak = 1'b0;
    end

    // R1: pulse lasts one cycle; reserved code gives nothing
    doReset();
    doToken(2'b00, v, c);
    @(negedge clk);
    check("R1 pulse width", respValid, 0);
    doToken(2'b11, v, c);
    check("R1 reserved token", v, 0);

    // R3: write with stall bit 0 has no effect, bit 1 sets
    doWrite(1'b0, 1'b0, 1'b0);
    check("R3 zero write", stallActive, 0);
    doWrite(1'b1, 1'b0, 1'b0);
    check("R3 set stall", stallActive, 1);

    // R4: SETUP clears stall; following IN uses FIFO path
    doToken(2'b10, v, c);
    check("R4 setup ack", c, 0);
    check("R4 stall cleared", stallActive, 0);
    txReady = 1'b1;
    doToken(2'b01, v, c);
    check("R4 IN after clear", c, 3);
    txReady = 1'b0;

    // R4: stall write in the same cycle as SETUP wins
    @(negedge clk);
    tokValid = 1'b1; tokType = 2'b10;
    wrEn = 1'b1; wrSetStall = 1'b1;
    @(negedge clk);
    tokValid = 1'b0; wrEn = 1'b0; wrSetStall = 1'b0;
    check("R4 same-cycle set wins", stallActive, 1);
    check("R2 setup ack with stall", respCode, 0);

    // R9: NAK set/clear and collisions
    doReset();
    doWrite(1'b0, 1'b1, 1'b0);
    check("R9 set nak", nakStatus, 1);
    doWrite(1'b0, 1'b0, 1'b1);
    check("R9 clear nak", nakStatus, 0);
    @(negedge clk);
    wrEn = 1'b1; wrClearNak = 1'b1; ctrlNakReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrClearNak = 1'b0; ctrlNakReq = 1'b0;
    check("R9 ctrl set beats clear", nakStatus, 1);
    doWrite(1'b0, 1'b0, 1'b1);
    doWrite(1'b0, 1'b1, 1'b1);
    check("R9 write set beats clear", nakStatus, 1);

    // R10: packet size decode
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mpsCode = 2'(k);
      #1;
      check($sformatf("R10 mps code %0d", k), maxPktBytes, 64 >> k);
    end

    finishRun();
  end

endmodule